// File: doc/BRIEF.md
# Multi-Port Broadcast Register Bank

This block holds the configuration registers of a device built from up to four identical ports. Each port has the same set of per-port registers, and a small set of global registers sits beside them. A host reaches any register through a synchronous interface. The interface carries a space bit that picks global or per-port registers, a port index, a register offset, write and read strobes, write data and registered read data.

A strap vector tells the block which ports physically exist in the variant. Only those ports accept writes and return data. Bit 0 of global register 0 is the broadcast bit. While it is set, one host write aimed at any present port lands in the same register offset of every present port. Per-port reads then return zero. Global reads keep working normally, so the host can still turn the mode off again.

Top module: `bcast_regs`

## Requirements
- R1: After reset, every per-port register, every global register, the broadcast bit and the read data output are all zero.
- R2: With broadcast off, a write to a present port's register at offset r changes only that port's register r.
- R3: With broadcast on (bit 0 of global offset 0 equal to 1), a write aimed at a present port at offset r stores the data at offset r of every present port. Other offsets keep their values.
- R4: Ports whose strap bit is 0 are absent. A write aimed at an absent port changes no register in either mode. A read of an absent port returns zero.
- R5: While broadcast is on, every per-port read returns zero. Once broadcast is turned off, per-port reads return the stored values again.
- R6: While broadcast is on, global register reads return the stored values.
- R7: Read data is loaded at the clock edge that samples the read strobe, from the register contents before any write in that cycle. It holds its value in every cycle without a read strobe.
- R8: A global offset at or above the global register count reads as zero, and a write to it is ignored.
- R9: The broadcast bit can only be changed by a global write. A per-port write at any offset, including offset 0, leaves the mode unchanged and is never copied into a global register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| portPresent | input | NUM_PORTS | Strap: bit p set means port p exists |
| hostGlobal | input | 1 | 1 selects the global register space, 0 the per-port space |
| hostPort | input | PORT_W | Target port index for per-port accesses |
| hostOffset | input | OFF_W | Register offset |
| hostWrEn | input | 1 | Write strobe, one cycle per write |
| hostRdEn | input | 1 | Read strobe, one cycle per read |
| hostWrData | input | DATA_W | Write data |
| hostRdData | output | DATA_W | Registered read data |

## Verification
A write becomes visible at the clock edge that samples its strobe. A read issued in the following cycle therefore already sees the new value, and so does a change of the broadcast mode. Read data is due one edge after the read strobe. The bench drives each strobe for exactly one cycle from a falling edge and samples the output at the next falling edge. Between reads it confirms that the output holds through idle and write cycles.

// File: rtl/bcast_regs_pkg.sv
package bcast_regs_pkg;

  // Strobes from the control decode to the register datapath
  typedef struct packed {
    logic wrSingle;  // write one present port
    logic wrAll;     // write same offset in every present port
    logic wrGlobal;  // write a global register
    logic rdLoad;    // load the read data register
    logic rdPort;    // read source is a per-port register
    logic rdGlobal;  // read source is a global register
  } hostStrobes_t;

  function automatic int unsigned idxWidth(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/bcast_regs_ctrl.sv
module bcast_regs_ctrl
  import bcast_regs_pkg::*;
#(
  parameter int unsigned NUM_PORTS   = 4,
  parameter int unsigned PORT_REGS   = 8,
  parameter int unsigned GLOBAL_REGS = 4,
  localparam int unsigned PORT_W = idxWidth(NUM_PORTS),
  localparam int unsigned OFF_W  = idxWidth((PORT_REGS > GLOBAL_REGS) ? PORT_REGS : GLOBAL_REGS)
) (
  input  logic [NUM_PORTS-1:0] portPresent,
  input  logic                 hostGlobal,
  input  logic [PORT_W-1:0]    hostPort,
  input  logic [OFF_W-1:0]     hostOffset,
  input  logic                 hostWrEn,
  input  logic                 hostRdEn,
  input  logic                 broadcastOn,
  output hostStrobes_t         strb
);

  logic portOk;
  logic portOffOk;
  logic globOffOk;
  logic portAccess;

  // Target port must exist in this variant
  always_comb begin
    portOk = 1'b0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (hostPort == PORT_W'(p) && portPresent[p]) portOk = 1'b1;
    end
  end

  assign portOffOk  = int'(hostOffset) < PORT_REGS;
  assign globOffOk  = int'(hostOffset) < GLOBAL_REGS;
  assign portAccess = !hostGlobal && portOk && portOffOk;

  always_comb begin
    strb          = '0;
    strb.wrSingle = hostWrEn && portAccess && !broadcastOn;
    strb.wrAll    = hostWrEn && portAccess && broadcastOn;
    strb.wrGlobal = hostWrEn && hostGlobal && globOffOk;
    strb.rdLoad   = hostRdEn;
    strb.rdPort   = portAccess && !broadcastOn;
    strb.rdGlobal = hostGlobal && globOffOk;
  end

endmodule

// File: rtl/bcast_regs_dpath.sv
module bcast_regs_dpath
  import bcast_regs_pkg::*;
#(
  parameter int unsigned NUM_PORTS   = 4,
  parameter int unsigned PORT_REGS   = 8,
  parameter int unsigned GLOBAL_REGS = 4,
  parameter int unsigned DATA_W      = 16,
  localparam int unsigned PORT_W = idxWidth(NUM_PORTS),
  localparam int unsigned OFF_W  = idxWidth((PORT_REGS > GLOBAL_REGS) ? PORT_REGS : GLOBAL_REGS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_PORTS-1:0] portPresent,
  input  logic [PORT_W-1:0]    hostPort,
  input  logic [OFF_W-1:0]     hostOffset,
  input  logic [DATA_W-1:0]    hostWrData,
  input  hostStrobes_t         strb,
  output logic [DATA_W-1:0]    hostRdData,
  output logic                 broadcastOn
);

  logic [DATA_W-1:0] portRegs [NUM_PORTS][PORT_REGS];
  logic [DATA_W-1:0] globRegs [GLOBAL_REGS];
  logic [DATA_W-1:0] portRead;
  logic [DATA_W-1:0] globRead;

  // Per-port storage; each copy qualifies the write with its own strap bit
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic portHit;
    assign portHit = portPresent[p] &&
                     (strb.wrAll || (strb.wrSingle && hostPort == PORT_W'(p)));
    for (genvar r = 0; r < PORT_REGS; r++) begin : g_reg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          portRegs[p][r] <= '0;
        else if (portHit && hostOffset == OFF_W'(r))
          portRegs[p][r] <= hostWrData;
      end
    end
  end

  for (genvar g = 0; g < GLOBAL_REGS; g++) begin : g_glob
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        globRegs[g] <= '0;
      else if (strb.wrGlobal && hostOffset == OFF_W'(g))
        globRegs[g] <= hostWrData;
    end
  end

  assign broadcastOn = globRegs[0][0];

  always_comb begin
    portRead = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      for (int r = 0; r < PORT_REGS; r++) begin
        if (hostPort == PORT_W'(p) && hostOffset == OFF_W'(r)) portRead = portRegs[p][r];
      end
    end
  end

  always_comb begin
    globRead = '0;
    for (int g = 0; g < GLOBAL_REGS; g++) begin
      if (hostOffset == OFF_W'(g)) globRead = globRegs[g];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      hostRdData <= '0;
    else if (strb.rdLoad) begin
      if (strb.rdPort)
        hostRdData <= portRead;
      else if (strb.rdGlobal)
        hostRdData <= globRead;
      else
        hostRdData <= '0;
    end
  end

endmodule

// File: rtl/bcast_regs.sv
module bcast_regs
  import bcast_regs_pkg::*;
#(
  parameter int unsigned NUM_PORTS   = 4,
  parameter int unsigned PORT_REGS   = 8,
  parameter int unsigned GLOBAL_REGS = 4,
  parameter int unsigned DATA_W      = 16,
  localparam int unsigned PORT_W = idxWidth(NUM_PORTS),
  localparam int unsigned OFF_W  = idxWidth((PORT_REGS > GLOBAL_REGS) ? PORT_REGS : GLOBAL_REGS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_PORTS-1:0] portPresent,
  input  logic                 hostGlobal,
  input  logic [PORT_W-1:0]    hostPort,
  input  logic [OFF_W-1:0]     hostOffset,
  input  logic                 hostWrEn,
  input  logic                 hostRdEn,
  input  logic [DATA_W-1:0]    hostWrData,
  output logic [DATA_W-1:0]    hostRdData
);

  hostStrobes_t strb;
  logic         broadcastOn;

  bcast_regs_ctrl #(
    .NUM_PORTS(NUM_PORTS), .PORT_REGS(PORT_REGS), .GLOBAL_REGS(GLOBAL_REGS)
  ) u_ctrl (
    .portPresent(portPresent), .hostGlobal(hostGlobal), .hostPort(hostPort),
    .hostOffset(hostOffset), .hostWrEn(hostWrEn), .hostRdEn(hostRdEn),
    .broadcastOn(broadcastOn), .strb(strb)
  );

  bcast_regs_dpath #(
    .NUM_PORTS(NUM_PORTS), .PORT_REGS(PORT_REGS), .GLOBAL_REGS(GLOBAL_REGS), .DATA_W(DATA_W)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .portPresent(portPresent), .hostPort(hostPort),
    .hostOffset(hostOffset), .hostWrData(hostWrData), .strb(strb),
    .hostRdData(hostRdData), .broadcastOn(broadcastOn)
  );

endmodule

// File: rtl/bcast_regs_checker.sv
module bcast_regs_checker
  import bcast_regs_pkg::*;
#(
  parameter int unsigned NUM_PORTS   = 4,
  parameter int unsigned PORT_REGS   = 8,
  parameter int unsigned GLOBAL_REGS = 4,
  parameter int unsigned DATA_W      = 16,
  localparam int unsigned PORT_W = idxWidth(NUM_PORTS),
  localparam int unsigned OFF_W  = idxWidth((PORT_REGS > GLOBAL_REGS) ? PORT_REGS : GLOBAL_REGS)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_PORTS-1:0] portPresent,
  input logic                 hostGlobal,
  input logic [PORT_W-1:0]    hostPort,
  input logic [OFF_W-1:0]     hostOffset,
  input logic                 hostWrEn,
  input logic                 hostRdEn,
  input logic [DATA_W-1:0]    hostRdData,
  input logic                 broadcastOn
);

  logic targetPresent;
  always_comb begin
    targetPresent = 1'b0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (hostPort == PORT_W'(p) && portPresent[p]) targetPresent = 1'b1;
    end
  end

  AST_RD_DATA_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !hostRdEn |=> $stable(hostRdData)); // R7

  AST_BCAST_PORT_RD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (hostRdEn && !hostGlobal && broadcastOn) |=> (hostRdData == '0)); // R5

  AST_ABSENT_PORT_RD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (hostRdEn && !hostGlobal && !targetPresent) |=> (hostRdData == '0)); // R4

  AST_GLOB_OOR_RD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (hostRdEn && hostGlobal && int'(hostOffset) >= GLOBAL_REGS) |=> (hostRdData == '0)); // R8

  AST_PORT_WR_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && !hostGlobal) |=> $stable(broadcastOn)); // R9

endmodule

bind bcast_regs bcast_regs_checker #(
  .NUM_PORTS(NUM_PORTS), .PORT_REGS(PORT_REGS), .GLOBAL_REGS(GLOBAL_REGS), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rstN(rstN), .portPresent(portPresent), .hostGlobal(hostGlobal),
  .hostPort(hostPort), .hostOffset(hostOffset), .hostWrEn(hostWrEn),
  .hostRdEn(hostRdEn), .hostRdData(hostRdData), .broadcastOn(broadcastOn)
);

// File: tb/bcast_regs_test.sv
module bcast_regs_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  portPresent = 4'b0111;
  logic        hostGlobal = 1'b0;
  logic [1:0]  hostPort = '0;
  logic [2:0]  hostOffset = '0;
  logic        hostWrEn = 1'b0;
  logic        hostRdEn = 1'b0;
  logic [15:0] hostWrData = '0;
  logic [15:0] hostRdData;

  int checks = 0;
  int errors = 0;

  logic [15:0] pexp [4][8];
  logic [15:0] gexp [4];

  always #10 clk = ~clk;

  bcast_regs uut (
    .clk(clk), .rstN(rstN), .portPresent(portPresent), .hostGlobal(hostGlobal),
    .hostPort(hostPort), .hostOffset(hostOffset), .hostWrEn(hostWrEn),
    .hostRdEn(hostRdEn), .hostWrData(hostWrData), .hostRdData(hostRdData)
  );

  task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] expRead(input logic g, input int p, input int r);
    if (g) return (r < 4) ? gexp[r] : 16'h0;
    if (portPresent[p] && !gexp[0][0]) return pexp[p][r];
    return 16'h0;
  endfunction

  task automatic doReset(input logic [3:0] strap);
    @(negedge clk);
    rstN = 1'b0;
    portPresent = strap;
    for (int p = 0; p < 4; p++) for (int r = 0; r < 8; r++) pexp[p][r] = '0;
    for (int g = 0; g < 4; g++) gexp[g] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic doWrite(input logic g, input int p, input int r, input logic [15:0] v);
    @(negedge clk);
    hostGlobal = g; hostPort = 2'(p); hostOffset = 3'(r); hostWrData = v; hostWrEn = 1'b1;
    @(negedge clk);
    hostWrEn = 1'b0;
    if (g) begin
      if (r < 4) gexp[r] = v;
    end else if (portPresent[p]) begin
      if (gexp[0][0]) begin
        for (int q = 0; q < 4; q++) if (portPresent[q]) pexp[q][r] = v;
      end else begin
        pexp[p][r] = v;
      end
    end
  endtask

  task automatic doRead(input string req, input logic g, input int p, input int r);
    logic [15:0] exp;
    exp = expRead(g, p, r);
    @(negedge clk);
    hostGlobal = g; hostPort = 2'(p); hostOffset = 3'(r); hostRdEn = 1'b1;
    @(negedge clk);
    hostRdEn = 1'b0;
    check(req, $sformatf("read g=%0d p=%0d r=%0d", g, p, r), hostRdData, exp);
  endtask

  task automatic sweepPorts(input string req);
    for (int p = 0; p < 4; p++) for (int r = 0; r < 8; r++) doRead(req, 1'b0, p, r);
  endtask

  task automatic sweepGlobals(input string req);
    for (int g = 0; g < 8; g++) doRead(req, 1'b1, 0, g);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R7 watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // Three-port variant
    doReset(4'b0111);
    check("R1", "read data after reset", hostRdData, 16'h0);
    sweepPorts("R1");
    sweepGlobals("R1");

    // Global scratch registers, plus out-of-range global offsets (R8)
    for (int g = 1; g < 8; g++) doWrite(1'b1, 0, g, 16'h00A0 + 16'(g));
    sweepGlobals("R8");

    // Individual writes to every port, absent port 3 included (R2, R4)
    for (int p = 0; p < 4; p++)
      for (int r = 0; r < 8; r++)
        doWrite(1'b0, p, r, 16'h0100 * 16'(p + 1) + 16'(r * 3) + 16'h5);
    sweepPorts("R2");
    doRead("R4", 1'b0, 3, 6);

    // Read data holds through idle and write cycles (R7)
    doRead("R7", 1'b0, 1, 4);
    repeat (3) @(negedge clk);
    check("R7", "hold over idle", hostRdData, pexp[1][4]);
    doWrite(1'b0, 1, 4, 16'hC0DE);
    check("R7", "hold over write", hostRdData, 16'h0100 * 16'd2 + 16'd17);

    // Read issued together with a write sees the old value (R7)
    @(negedge clk);
    hostGlobal = 1'b0; hostPort = 2'd2; hostOffset = 3'd3; hostWrData = 16'h4444;
    hostWrEn = 1'b1; hostRdEn = 1'b1;
    @(negedge clk);
    hostWrEn = 1'b0; hostRdEn = 1'b0;
    check("R7", "read with same-cycle write", hostRdData, pexp[2][3]);
    pexp[2][3] = 16'h4444;
    doRead("R7", 1'b0, 2, 3);

    // Broadcast on: per-port reads zero, global reads valid (R5, R6)
    doWrite(1'b1, 0, 0, 16'h0001);
    sweepPorts("R5");
    sweepGlobals("R6");

    // Broadcast writes (R3), absent-port trigger ignored (R4), offset 0 keeps mode (R9)
    doWrite(1'b0, 1, 2, 16'hBEEF);
    doWrite(1'b0, 3, 5, 16'h7777);
    doWrite(1'b0, 2, 0, 16'h0000);
    doRead("R9", 1'b0, 0, 3);
    doRead("R9", 1'b1, 0, 0);

    // Broadcast off: stored values visible again (R3, R4, R5)
    doWrite(1'b1, 0, 0, 16'h0000);
    sweepPorts("R3");

    // Sparse variant: only ports 1 and 3 exist
    doReset(4'b1010);
    doWrite(1'b1, 0, 0, 16'h0001);
    doWrite(1'b0, 3, 7, 16'h5A5A);
    doWrite(1'b0, 0, 1, 16'h1234);
    doWrite(1'b0, 1, 1, 16'h2468);
    doWrite(1'b1, 0, 0, 16'h0000);
    check("R3", "sparse port 1 offset 7", expRead(1'b0, 1, 7), 16'h5A5A);
    sweepPorts("R3");
    doWrite(1'b0, 2, 6, 16'h9999);
    doRead("R4", 1'b0, 2, 6);
    doRead("R2", 1'b0, 3, 6);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule